// File: doc/BRIEF.md
# CAN Controller Interrupt Flag and Mask Unit

This block holds the interrupt state of a CAN controller. Seven event sources each set a sticky flag: receive overrun, bus error, transmit complete, receive pending, error-passive change, error-warning change and arbitration lost. The CPU clears a flag by writing a 1 to its position. A mask register enables each source, and one registered interrupt line asserts when any enabled flag is set.

Two acknowledgements have side effects. Acknowledging the receive flag consumes one stored message: it decrements a saturating 5-bit message counter and pulses a strobe toward the receive FIFO. Acknowledging the transmit flag pulses a strobe that rewinds the transmit buffer write pointer. The receive flag is not a plain sticky bit. It reads as set whenever the counter is non-zero, so it stays set until the last stored message has been acknowledged. The protocol engine and the buffer memories sit outside this block.

Top module: `can_irq_ctrl`

## Requirements
- R1: After reset, status, mask, message count, interrupt line and both strobes are all 0.
- R2: Status bit positions from bit 0 up: overrun, bus error, transmit complete, receive pending, error-passive, error-warning, arbitration lost. Bit 7 always reads 0. A pulse on evt_i[k] sets status bit k at the next clock edge, and the bit stays set until it is cleared. This applies to every k except 3.
- R3: A status write (stat_wr_i high) clears each status bit written with 1 and leaves each bit written with 0 unchanged.
- R4: If an event and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R5: A mask write (mask_wr_i high) loads bits 6..0 of mask_wdata_i into mask_o at the next edge. mask_o bit 7 always reads 0. A mask bit of 1 enables the source at the same position.
- R6: irq_o is a register. It is 1 in the cycle after status_o AND mask_o is non-zero, and 0 in the cycle after it is zero.
- R7: evt_i[3] marks one message stored and raises msg_cnt_o by 1 at the next edge. The count holds at 31.
- R8: A status write with bit 3 set lowers msg_cnt_o by 1 at the next edge, holding at 0, and drives rx_ack_o high for exactly the cycle after the write.
- R9: status_o bit 3 reads 1 exactly when msg_cnt_o is non-zero. A stored-message event and a bit-3 acknowledge in the same cycle leave the count unchanged, including at 31.
- R10: A status write with bit 2 set drives tx_ptr_rst_o high for exactly the cycle after the write. A write with bit 2 at 0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | One-cycle event pulses, one per source |
| stat_wr_i | input | 1 | Status write-1-to-clear strobe |
| stat_wdata_i | input | 8 | Status write data |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| status_o | output | 8 | Interrupt status flags |
| mask_o | output | 8 | Interrupt enable mask |
| msg_cnt_o | output | 5 | Stored receive message count |
| irq_o | output | 1 | Registered interrupt request |
| rx_ack_o | output | 1 | Pulse: one received message consumed |
| tx_ptr_rst_o | output | 1 | Pulse: rewind transmit buffer write pointer |

## Verification
The bench fires a set event and a clear at the same bit in the same cycle. A design that gave the clear priority would lose that event. It acknowledges with an empty counter and raises events with the counter at 31. A design without saturation would wrap to 31 or to 0 and corrupt the receive flag. It fires an event and an acknowledge together at 31 to catch an adder that saturates before it subtracts. It also checks the one-cycle lag of irq_o after a mask change, that writes of zero and writes to bit 7 have no effect, and that each strobe follows only its own bit.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_SRC  = 7;
  localparam int CNT_W    = 5;
  localparam int BIT_OVR  = 0;
  localparam int BIT_BERR = 1;
  localparam int BIT_TX   = 2;
  localparam int BIT_RX   = 3;
  localparam int BIT_EPAS = 4;
  localparam int BIT_EWRN = 5;
  localparam int BIT_ARB  = 6;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int REG_W    = 8,
  parameter int NUM_SRC  = 7,
  parameter int SKIP_BIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] flag_o
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i < NUM_SRC && i != SKIP_BIT) begin : g_flag
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign flag_o[i] = q;

      // R4
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> flag_o[i]);
      // R3
      clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
      // R2
      sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
    end else begin : g_tie
      logic unused_bit;
      assign unused_bit = set_i[i] ^ clr_i[i];
      assign flag_o[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/rx_msg_counter.sv
module rx_msg_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
  assign cnt_o = cnt_q;

  // R7
  no_wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && inc_i) |=> cnt_o == CNT_MAX);
  // R8
  no_wrap_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && dec_i && !inc_i) |=> cnt_o == '0);
  // R9
  inc_dec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(cnt_o));
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter int P_REG_W   = REG_W,
  parameter int P_NUM_SRC = NUM_SRC,
  parameter int P_CNT_W   = CNT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [P_NUM_SRC-1:0] evt_i,
  input  logic                 stat_wr_i,
  input  logic [P_REG_W-1:0]   stat_wdata_i,
  input  logic                 mask_wr_i,
  input  logic [P_REG_W-1:0]   mask_wdata_i,
  output logic [P_REG_W-1:0]   status_o,
  output logic [P_REG_W-1:0]   mask_o,
  output logic [P_CNT_W-1:0]   msg_cnt_o,
  output logic                 irq_o,
  output logic                 rx_ack_o,
  output logic                 tx_ptr_rst_o
);
  localparam logic [P_REG_W-1:0] SRC_MASK =
    {{(P_REG_W-P_NUM_SRC){1'b0}}, {P_NUM_SRC{1'b1}}};

  logic [P_REG_W-1:0] set_vec, clr_vec, flags, status, mask_q;
  logic [P_CNT_W-1:0] cnt;
  logic               irq_q, rx_ack_q, tx_rst_q;

  assign set_vec = {{(P_REG_W-P_NUM_SRC){1'b0}}, evt_i};
  assign clr_vec = stat_wr_i ? stat_wdata_i : '0;

  irq_flag_bank #(
    .REG_W(P_REG_W), .NUM_SRC(P_NUM_SRC), .SKIP_BIT(BIT_RX)
  ) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(set_vec), .clr_i(clr_vec), .flag_o(flags)
  );

  rx_msg_counter #(.CNT_W(P_CNT_W)) u_rx_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(evt_i[BIT_RX]), .dec_i(clr_vec[BIT_RX]), .cnt_o(cnt)
  );

  // receive flag tracks the stored-message count
  always_comb begin
    status         = flags;
    status[BIT_RX] = (cnt != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      irq_q    <= 1'b0;
      rx_ack_q <= 1'b0;
      tx_rst_q <= 1'b0;
    end else begin
      if (mask_wr_i) mask_q <= mask_wdata_i & SRC_MASK;
      irq_q    <= |(status & mask_q);
      rx_ack_q <= clr_vec[BIT_RX];
      tx_rst_q <= clr_vec[BIT_TX];
    end
  end

  assign status_o     = status;
  assign mask_o       = mask_q;
  assign msg_cnt_o    = cnt;
  assign irq_o        = irq_q;
  assign rx_ack_o     = rx_ack_q;
  assign tx_ptr_rst_o = tx_rst_q;

  // R6
  irq_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & mask_o) != '0) |=> irq_o);
  // R6
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & mask_o) == '0) |=> !irq_o);
  // R8
  rx_ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && stat_wdata_i[BIT_RX]) |=> rx_ack_o);
  // R10
  tx_rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stat_wr_i && stat_wdata_i[BIT_TX]) |=> !tx_ptr_rst_o);
  // R5
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr_i |=> $stable(mask_o));
endmodule

// File: tb/can_irq_ctrl_bench.sv
`timescale 1ns/1ps
module can_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt = '0;
  logic       swr = 1'b0, mwr = 1'b0;
  logic [7:0] sdata = '0, mdata = '0;
  logic [7:0] status, mask;
  logic [4:0] cnt;
  logic       irq, rx_ack, tx_rst;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_irq_ctrl u_can_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .stat_wr_i(swr), .stat_wdata_i(sdata),
    .mask_wr_i(mwr), .mask_wdata_i(mdata),
    .status_o(status), .mask_o(mask), .msg_cnt_o(cnt),
    .irq_o(irq), .rx_ack_o(rx_ack), .tx_ptr_rst_o(tx_rst)
  );

  typedef struct packed {
    logic [6:0] evt; logic swr; logic [7:0] sdata;
    logic mwr; logic [7:0] mdata; logic [7:0] est; logic [7:0] emask;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{7'h01, 1'b0, 8'h00, 1'b1, 8'h01, 8'h01, 8'h01},
    '{7'h00, 1'b0, 8'h00, 1'b0, 8'h00, 8'h01, 8'h01},
    '{7'h44, 1'b0, 8'h00, 1'b0, 8'h00, 8'h45, 8'h01},
    '{7'h00, 1'b1, 8'h01, 1'b0, 8'h00, 8'h44, 8'h01},
    '{7'h00, 1'b0, 8'h00, 1'b0, 8'h00, 8'h44, 8'h01},
    '{7'h00, 1'b0, 8'h00, 1'b1, 8'hFF, 8'h44, 8'h7F},
    '{7'h00, 1'b0, 8'h00, 1'b0, 8'h00, 8'h44, 8'h7F},
    '{7'h02, 1'b1, 8'h02, 1'b0, 8'h00, 8'h46, 8'h7F},
    '{7'h00, 1'b1, 8'h84, 1'b0, 8'h00, 8'h42, 8'h7F},
    '{7'h30, 1'b0, 8'h00, 1'b0, 8'h00, 8'h72, 8'h7F},
    '{7'h00, 1'b1, 8'h72, 1'b0, 8'h00, 8'h00, 8'h7F},
    '{7'h00, 1'b0, 8'h00, 1'b1, 8'h00, 8'h00, 8'h00},
    '{7'h01, 1'b0, 8'h00, 1'b0, 8'h00, 8'h01, 8'h00},
    '{7'h00, 1'b1, 8'h00, 1'b0, 8'h00, 8'h01, 8'h00},
    '{7'h00, 1'b0, 8'h00, 1'b0, 8'h00, 8'h01, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, pass one posedge, return at the following negedge
  task automatic cyc(input logic [6:0] e, input logic sw, input logic [7:0] sd,
                     input logic mw, input logic [7:0] md);
    evt = e; swr = sw; sdata = sd; mwr = mw; mdata = md;
    @(posedge clk);
    @(negedge clk);
    evt = '0; swr = 1'b0; sdata = '0; mwr = 1'b0; mdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] pst, pmk;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 status", status, 8'h00);
    chk("R1 mask", mask, 8'h00);
    chk("R1 count", cnt, 5'd0);
    chk("R1 strobes/irq", {irq, rx_ack, tx_rst}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6: table walk
    pst = 8'h00; pmk = 8'h00;
    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].evt, TBL[i].swr, TBL[i].sdata, TBL[i].mwr, TBL[i].mdata);
      chk($sformatf("R2/R3/R4 status row %0d", i), status, TBL[i].est);
      chk($sformatf("R5 mask row %0d", i), mask, TBL[i].emask);
      chk($sformatf("R6 irq row %0d", i), irq, |(pst & pmk));
      pst = TBL[i].est; pmk = TBL[i].emask;
    end

    // clear leftovers, enable receive source only
    cyc(7'h00, 1'b1, 8'h7F, 1'b1, 8'h08);
    chk("R3 cleared", status, 8'h00);

    // R7 R9: stored messages raise count and receive flag
    for (int k = 0; k < 3; k++) cyc(7'h08, 1'b0, 8'h00, 1'b0, 8'h00);
    chk("R7 count 3", cnt, 5'd3);
    chk("R9 rx flag set", status, 8'h08);
    chk("R6 irq from rx", irq, 1'b1);

    // R8 R9: acknowledge keeps flag while messages remain
    cyc(7'h00, 1'b1, 8'h08, 1'b0, 8'h00);
    chk("R8 count 2", cnt, 5'd2);
    chk("R8 rx_ack pulse", rx_ack, 1'b1);
    chk("R9 rx flag kept", status[3], 1'b1);
    cyc(7'h00, 1'b0, 8'h00, 1'b0, 8'h00);
    chk("R8 rx_ack single", rx_ack, 1'b0);
    cyc(7'h00, 1'b1, 8'h08, 1'b0, 8'h00);
    cyc(7'h00, 1'b1, 8'h08, 1'b0, 8'h00);
    chk("R8 count 0", cnt, 5'd0);
    chk("R9 rx flag cleared", status[3], 1'b0);
    cyc(7'h00, 1'b1, 8'h08, 1'b0, 8'h00);
    chk("R8 floor at 0", cnt, 5'd0);
    chk("R8 ack pulse at 0", rx_ack, 1'b1);

    // R9: event plus ack together
    cyc(7'h08, 1'b0, 8'h00, 1'b0, 8'h00);
    cyc(7'h08, 1'b1, 8'h08, 1'b0, 8'h00);
    chk("R9 inc+dec hold", cnt, 5'd1);
    chk("R9 rx flag with inc+dec", status[3], 1'b1);

    // R7: saturation
    for (int k = 0; k < 32; k++) cyc(7'h08, 1'b0, 8'h00, 1'b0, 8'h00);
    chk("R7 saturate 31", cnt, 5'd31);
    cyc(7'h08, 1'b0, 8'h00, 1'b0, 8'h00);
    chk("R7 stay 31", cnt, 5'd31);
    cyc(7'h08, 1'b1, 8'h08, 1'b0, 8'h00);
    chk("R9 inc+dec at 31", cnt, 5'd31);
    cyc(7'h00, 1'b1, 8'h08, 1'b0, 8'h00);
    chk("R8 dec from 31", cnt, 5'd30);

    // R10: transmit pointer rewind strobe
    cyc(7'h00, 1'b1, 8'h04, 1'b0, 8'h00);
    chk("R10 tx strobe", tx_rst, 1'b1);
    chk("R8 no rx_ack on tx write", rx_ack, 1'b0);
    cyc(7'h00, 1'b0, 8'h00, 1'b0, 8'h00);
    chk("R10 tx strobe single", tx_rst, 1'b0);
    cyc(7'h00, 1'b1, 8'h00, 1'b0, 8'h00);
    chk("R10 no strobe on zero write", tx_rst, 1'b0);
    chk("R3 zero write keeps count", cnt, 5'd30);

    // R1: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset count", cnt, 5'd0);
    chk("R1 reset status/mask", {status, mask}, 16'h0000);
    finish_run();
  end
endmodule